// File: doc/BRIEF.md
# Atomic Read-Modify-Write Line Locker

This block sits beside a small private cache and turns a read-modify-write request from its core into an operation that no other agent can split. A request carries a byte address, an operation code, an operand and a compare value. The block checks the request first. It then waits until the core's earlier memory traffic has drained, and locks the cache line. If the line is not already owned, it asks the other caches to drop their copies. After that it changes the addressed word in place, unlocks the line and returns the value the word held before.

Other agents read lines through a snoop port. A snoop to any line that is not locked is answered on the next cycle, and it downgrades an owned line to Shared. A snoop that hits the locked line is parked in a single holding register. It is answered only after the atomic operation has finished, so it sees the new value. A plain read followed later by a write gets none of this protection: between them, every snoop is answered at once.

Top module: `atomicLineLocker`

## Requirements
- R1: After reset, reqReady is 1, rspValid, invReq and snpRspValid are 0, and every word of every line reads as zero through a snoop.
- R2: Operation code 0 (fetch-add) returns the old word in rspOld with rspErr 0, and stores old plus operand (modulo 2^32). rspValid is a one-cycle pulse.
- R3: Operation code 1 (exchange) returns the old word and stores the operand.
- R4: Operation code 2 (compare-exchange) returns the old word. It stores the operand only when the old word equals the compare value; otherwise the word is left unchanged.
- R5: Operation code 3, or an address with nonzero bits [1:0], gets a response with rspErr 1. The block takes no lock, raises no invReq and changes no word.
- R6: While drained is 0, no lock is taken. Neither invReq nor rspValid is raised for a request that has been accepted.
- R7: If the target line is Invalid or Shared, invReq is raised with invLine equal to the line index. invReq stays high until invAck is seen, and the word is changed only after that.
- R8: Line state is a 2-bit field (0 Invalid, 1 Shared, 2 Exclusive, 3 Modified), and all lines reset to Shared. An operation on a line held Exclusive or Modified raises no invReq, and every completed operation leaves its line Modified.
- R9: A snoop that hits the locked line is held. It is answered only after the cycle in which rspValid pulses, and it returns the updated word.
- R10: A snoop to any other line, even during an atomic operation, is answered in the cycle after it is accepted.
- R11: A snoop answer downgrades a Modified or Exclusive line to Shared, so the next atomic operation on that line again raises invReq.

Address layout: bits [1:0] are the byte offset, bits [3:2] select the word in the line, and bits [5:4] select the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Atomic request present |
| reqReady | output | 1 | Block idle, request accepted this cycle |
| reqOp | input | 2 | 0 add, 1 exchange, 2 compare-exchange, 3 invalid |
| reqAddr | input | ADDR_W (6) | Byte address of the target word |
| reqOperand | input | DATA_W (32) | Addend or new value |
| reqCompare | input | DATA_W (32) | Expected value for compare-exchange |
| drained | input | 1 | Earlier loads and stores of the core are complete |
| rspValid | output | 1 | One-cycle response pulse |
| rspErr | output | 1 | Request rejected |
| rspOld | output | DATA_W (32) | Word value before the operation |
| invReq | output | 1 | Ask other caches to give up the line |
| invLine | output | IDX_W (2) | Line being invalidated |
| invAck | input | 1 | Other copies are gone |
| snpValid | input | 1 | Snoop read from another agent |
| snpReady | output | 1 | Snoop can be accepted |
| snpAddr | input | ADDR_W (6) | Snooped byte address |
| snpRspValid | output | 1 | Snoop answer present |
| snpRspData | output | DATA_W (32) | Snooped word |

## Verification
A wrong line state shows up at the next atomic operation on that line. Either invReq appears where it should not, or it is missing, in the cycle after the lock is taken. A lock that is lost or never released shows up as a snoop answer that comes too early and carries the stale word, or as one that never comes at all. A fault in the operate step shows in rspOld, and in the value a later snoop reads, within a few cycles of invAck.

// File: rtl/lockerPkg.sv
package lockerPkg;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SWAP = 2'd1, OP_CAS = 2'd2, OP_BAD = 2'd3} atomOp_e;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} lineState_e;
  typedef struct packed {
    logic capture;
    logic lockSet;
    logic grantOwn;
    logic operate;
    logic lockClr;
  } dpStrobe_t;
endpackage

// File: rtl/lockerCtrl.sv
module lockerCtrl
  import lockerPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      drained,
  input  logic      invAck,
  input  logic      reqBad,
  input  logic      lineOwned,
  input  logic      lockActive,
  output logic      reqReady,
  output logic      invReq,
  output logic      rspValid,
  output logic      rspErr,
  output dpStrobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_DRAIN, ST_LOCK, ST_INVAL, ST_OPER, ST_REL, ST_RESP
  } ctrlState_e;

  ctrlState_e st, stNext;
  logic errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      errQ <= 1'b0;
    end else begin
      st <= stNext;
      if (st == ST_CHECK) errQ <= reqBad;
    end
  end

  always_comb begin
    stNext   = st;
    strobe   = '0;
    reqReady = 1'b0;
    invReq   = 1'b0;
    rspValid = 1'b0;
    unique case (st)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          stNext = ST_CHECK;
        end
      end
      ST_CHECK: stNext = reqBad ? ST_RESP : ST_DRAIN;
      ST_DRAIN: if (drained) begin
        strobe.lockSet = 1'b1;
        stNext = ST_LOCK;
      end
      ST_LOCK:  stNext = lineOwned ? ST_OPER : ST_INVAL;
      ST_INVAL: begin
        invReq = 1'b1;
        if (invAck) begin
          strobe.grantOwn = 1'b1;
          stNext = ST_OPER;
        end
      end
      ST_OPER: begin
        strobe.operate = 1'b1;
        stNext = ST_REL;
      end
      ST_REL: begin
        strobe.lockClr = 1'b1;
        stNext = ST_RESP;
      end
      ST_RESP: begin
        rspValid = 1'b1;
        stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign rspErr = rspValid & errQ;

  // R7
  inv_needs_lock_chk: assert property (@(posedge clk) disable iff (!rstN) invReq |-> lockActive);
  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) rspValid |=> !rspValid);
  // R5
  err_nolock_chk: assert property (@(posedge clk) disable iff (!rstN) rspErr |-> !lockActive);
  // R6
  drain_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_DRAIN && !drained) |=> !lockActive);
endmodule

// File: rtl/lockerData.sv
module lockerData
  import lockerPkg::*;
#(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int ADDR_W = IDX_W + OFF_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqOperand,
  input  logic [DATA_W-1:0] reqCompare,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpReady,
  output logic              snpRspValid,
  output logic [DATA_W-1:0] snpRspData,
  output logic              reqBad,
  output logic              lineOwned,
  output logic              lockActive,
  output logic [IDX_W-1:0]  lockLine,
  output logic [DATA_W-1:0] oldWord
);
  logic [DATA_W-1:0] mem [LINES][WORDS];
  logic [LINES-1:0][1:0] stateVec;
  logic [LINES-1:0] demote;

  logic [1:0]        opQ;
  logic              misQ;
  logic [IDX_W-1:0]  reqIdx;
  logic [OFF_W-1:0]  reqOff;
  logic [DATA_W-1:0] operandQ, cmpQ;

  logic              pendValid;
  logic [IDX_W-1:0]  pendIdx, ansIdx, rspLineQ;
  logic [OFF_W-1:0]  pendOff, ansOff;

  wire [IDX_W-1:0] snpIdx = snpAddr[ADDR_W-1 -: IDX_W];
  wire [OFF_W-1:0] snpOff = snpAddr[OFF_W+1:2];

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= '0; misQ <= 1'b0; reqIdx <= '0; reqOff <= '0;
      operandQ <= '0; cmpQ <= '0;
    end else if (strobe.capture) begin
      opQ      <= reqOp;
      misQ     <= |reqAddr[1:0];
      reqIdx   <= reqAddr[ADDR_W-1 -: IDX_W];
      reqOff   <= reqAddr[OFF_W+1:2];
      operandQ <= reqOperand;
      cmpQ     <= reqCompare;
    end
  end

  assign reqBad = (opQ == OP_BAD) || misQ;

  // lock register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockActive <= 1'b0;
      lockLine   <= '0;
    end else if (strobe.lockSet) begin
      lockActive <= 1'b1;
      lockLine   <= reqIdx;
    end else if (strobe.lockClr) begin
      lockActive <= 1'b0;
    end
  end

  // operate unit
  wire [DATA_W-1:0] curWord = mem[reqIdx][reqOff];
  logic [DATA_W-1:0] newWord;
  always_comb begin
    unique case (opQ)
      OP_ADD:  newWord = curWord + operandQ;
      OP_SWAP: newWord = operandQ;
      OP_CAS:  newWord = (curWord == cmpQ) ? operandQ : curWord;
      default: newWord = curWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < LINES; l++)
        for (int w = 0; w < WORDS; w++)
          mem[l][w] <= '0;
      oldWord <= '0;
    end else if (strobe.operate) begin
      mem[reqIdx][reqOff] <= newWord;
      oldWord <= curWord;
    end
  end

  // per-line coherence state
  for (genvar g = 0; g < LINES; g++) begin : gLine
    lineState_e lineSt;
    wire isMine = (reqIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) lineSt <= LS_S;
      else if (strobe.operate && isMine) lineSt <= LS_M;
      else if (strobe.grantOwn && isMine) lineSt <= LS_E;
      else if (demote[g] && (lineSt == LS_M || lineSt == LS_E)) lineSt <= LS_S;
    end
    assign stateVec[g] = lineSt;
  end

  assign lineOwned = (stateVec[reqIdx] == LS_E) || (stateVec[reqIdx] == LS_M);

  // snoop handling with one holding slot
  wire hitLock    = lockActive && (snpIdx == lockLine);
  wire acceptNow  = snpValid && !pendValid;
  wire answerImm  = acceptNow && !hitLock;
  wire pendAnswer = pendValid && !(lockActive && (pendIdx == lockLine));
  wire answerAny  = answerImm || pendAnswer;

  assign snpReady = !pendValid;
  assign ansIdx   = pendAnswer ? pendIdx : snpIdx;
  assign ansOff   = pendAnswer ? pendOff : snpOff;

  always_comb begin
    demote = '0;
    if (answerAny) demote[ansIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid   <= 1'b0;
      pendIdx     <= '0;
      pendOff     <= '0;
      snpRspValid <= 1'b0;
      snpRspData  <= '0;
      rspLineQ    <= '0;
    end else begin
      snpRspValid <= answerAny;
      if (answerAny) begin
        snpRspData <= mem[ansIdx][ansOff];
        rspLineQ   <= ansIdx;
      end
      if (acceptNow && hitLock) begin
        pendValid <= 1'b1;
        pendIdx   <= snpIdx;
        pendOff   <= snpOff;
      end else if (pendAnswer) begin
        pendValid <= 1'b0;
      end
    end
  end

  // R9
  defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpRspValid && lockActive) |-> (rspLineQ != lockLine));
  // R7
  oper_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.operate |-> lineOwned);
endmodule

// File: rtl/atomicLineLocker.sv
module atomicLineLocker
  import lockerPkg::*;
#(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int ADDR_W = IDX_W + OFF_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqOperand,
  input  logic [DATA_W-1:0] reqCompare,
  input  logic              drained,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspOld,
  output logic              invReq,
  output logic [IDX_W-1:0]  invLine,
  input  logic              invAck,
  input  logic              snpValid,
  output logic              snpReady,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpRspValid,
  output logic [DATA_W-1:0] snpRspData
);
  dpStrobe_t strobe;
  logic reqBad, lineOwned, lockActive;

  lockerCtrl uCtrl (
    .clk, .rstN, .reqValid, .drained, .invAck,
    .reqBad, .lineOwned, .lockActive,
    .reqReady, .invReq, .rspValid, .rspErr, .strobe
  );

  lockerData #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) uData (
    .clk, .rstN, .strobe, .reqOp, .reqAddr, .reqOperand, .reqCompare,
    .snpValid, .snpAddr, .snpReady, .snpRspValid, .snpRspData,
    .reqBad, .lineOwned, .lockActive, .lockLine(invLine), .oldWord(rspOld)
  );
endmodule

// File: tb/tb_atomicLineLocker.sv
`timescale 1ns/1ps
module tb_atomicLineLocker;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqReady;
  logic [1:0] reqOp = 0;
  logic [5:0] reqAddr = 0;
  logic [31:0] reqOperand = 0, reqCompare = 0;
  logic drained = 1;
  logic rspValid, rspErr;
  logic [31:0] rspOld;
  logic invReq, invAck = 0;
  logic [1:0] invLine;
  logic snpValid = 0, snpReady;
  logic [5:0] snpAddr = 0;
  logic snpRspValid;
  logic [31:0] snpRspData;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  atomicLineLocker dut (.*);

  function automatic logic [5:0] mkAddr(int line, int word);
    return {line[1:0], word[1:0], 2'b00};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic atomic(input logic [1:0] op, input logic [5:0] addr,
                        input logic [31:0] operand, input logic [31:0] cmp,
                        input int holdDrain,
                        output logic [31:0] old, output logic err, output bit sawInv);
    sawInv = 0; old = 'x; err = 'x;
    @(negedge clk);
    reqValid = 1; reqOp = op; reqAddr = addr; reqOperand = operand; reqCompare = cmp;
    @(negedge clk);
    reqValid = 0;
    if (holdDrain > 0) begin
      drained = 0;
      for (int i = 0; i < holdDrain; i++) begin
        @(negedge clk);
        // R6 nothing proceeds while not drained
        check("R6 invReq", invReq, 0);
        check("R6 rspValid", rspValid, 0);
      end
      drained = 1;
    end
    for (int i = 0; i < 60; i++) begin
      if (rspValid) begin
        old = rspOld; err = rspErr;
        break;
      end
      if (invReq && !invAck) begin
        sawInv = 1;
        check("R7 invLine", invLine, addr[5:4]);
        invAck = 1;
      end else invAck = 0;
      @(negedge clk);
    end
    invAck = 0;
  endtask

  task automatic snoopNow(input logic [5:0] addr, output logic [31:0] data);
    @(negedge clk);
    snpValid = 1; snpAddr = addr;
    @(negedge clk);
    snpValid = 0;
    // R10 immediate answer
    check("R10 snoop answered next cycle", snpRspValid, 1);
    data = snpRspData;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 reqReady", reqReady, 1);
    check("R1 rspValid", rspValid, 0);
    check("R1 invReq", invReq, 0);
    check("R1 snpRspValid", snpRspValid, 0);
    snoopNow(mkAddr(0, 2), d);
    check("R1 word zero", d, 0);
  endtask

  task automatic testAdd();
    logic [31:0] old, d; logic err; bit inv;
    atomic(2'd0, mkAddr(1, 0), 32'd5, 0, 0, old, err, inv);
    check("R2 old", old, 0);
    check("R2 err", err, 0);
    check("R7 inv on shared line", inv, 1);
    @(negedge clk);
    check("R2 single pulse", rspValid, 0);
    atomic(2'd0, mkAddr(1, 0), 32'd7, 0, 0, old, err, inv);
    check("R2 old second", old, 5);
    check("R8 no inv on modified line", inv, 0);
    snoopNow(mkAddr(1, 0), d);
    check("R2 stored sum", d, 12);
    atomic(2'd0, mkAddr(1, 0), 32'hFFFF_FFFF, 0, 0, old, err, inv);
    check("R11 inv after snoop downgrade", inv, 1);
    check("R2 old third", old, 12);
    snoopNow(mkAddr(1, 0), d);
    check("R2 wrapped sum", d, 11);
  endtask

  task automatic testSwapCas();
    logic [31:0] old, d; logic err; bit inv;
    atomic(2'd1, mkAddr(2, 3), 32'hAA, 0, 0, old, err, inv);
    check("R3 old", old, 0);
    atomic(2'd1, mkAddr(2, 3), 32'h55, 0, 0, old, err, inv);
    check("R3 old swapped", old, 32'hAA);
    atomic(2'd2, mkAddr(2, 3), 32'h99, 32'h55, 0, old, err, inv);
    check("R4 cas hit old", old, 32'h55);
    atomic(2'd2, mkAddr(2, 3), 32'h77, 32'h1, 0, old, err, inv);
    check("R4 cas miss old", old, 32'h99);
    snoopNow(mkAddr(2, 3), d);
    check("R4 cas miss keeps word", d, 32'h99);
  endtask

  task automatic testErrors();
    logic [31:0] old, d; logic err; bit inv;
    atomic(2'd3, mkAddr(0, 1), 32'h3, 0, 0, old, err, inv);
    check("R5 bad op err", err, 1);
    check("R5 bad op no inv", inv, 0);
    atomic(2'd1, mkAddr(0, 1) | 6'd2, 32'h3, 0, 0, old, err, inv);
    check("R5 misaligned err", err, 1);
    check("R5 misaligned no inv", inv, 0);
    snoopNow(mkAddr(0, 1), d);
    check("R5 word unchanged", d, 0);
  endtask

  task automatic testDrain();
    logic [31:0] old; logic err; bit inv;
    atomic(2'd0, mkAddr(0, 0), 32'd3, 0, 8, old, err, inv);
    check("R6 completes after drain", err, 0);
    check("R6 old", old, 0);
  endtask

  task automatic testDefer();
    logic [31:0] d;
    int rspAt = -1, snpAt = -1;
    @(negedge clk);
    reqValid = 1; reqOp = 2'd0; reqAddr = mkAddr(3, 1); reqOperand = 32'd4;
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 20 && !invReq; i++) @(negedge clk);
    check("R7 inv raised for deferral", invReq, 1);
    // snoop another line while locked
    snpValid = 1; snpAddr = mkAddr(0, 0);
    @(negedge clk);
    snpValid = 0;
    check("R10 other line answered during lock", snpRspValid, 1);
    check("R10 other line data", snpRspData, 3);
    snpValid = 1; snpAddr = mkAddr(3, 1);
    @(negedge clk);
    snpValid = 0;
    for (int i = 0; i < 5; i++) begin
      check("R9 locked line held", snpRspValid, 0);
      check("R7 inv held until ack", invReq, 1);
      @(negedge clk);
    end
    invAck = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      invAck = 0;
      if (rspValid && rspAt < 0) rspAt = i;
      if (snpRspValid && snpAt < 0) begin
        snpAt = i; d = snpRspData;
      end
    end
    check("R9 response seen", rspAt >= 0, 1);
    check("R9 snoop after response", snpAt > rspAt, 1);
    check("R9 snoop sees new word", d, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testAdd();
    testSwapCas();
    testErrors();
    testDrain();
    testDefer();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule